// File: doc/BRIEF.md
# Uncached Load Request Buffer

This block holds uncached load requests between the load pipeline and a bus-side access buffer. Each request from the pipeline takes one slot out of a small pool of entries. Every entry runs its own four-state sequence. A free list of idle entries decides which slot a new request takes. If no slot is free, the pipeline is told to replay the load later.

Entries that are waiting to go out compete for a single outgoing request channel. The entry with the oldest program-order age tag wins. Each outgoing request carries its entry index as a transaction id, and each bus response names the entry it belongs to by that id. An entry that holds its data competes, again by age, for the writeback port back to the pipeline. It returns to the free list once the pipeline accepts the writeback.

A pipeline flush removes every entry whose age is the same as or younger than the flush age. An entry that was already sent on the bus cannot be recalled. It stays in place until its response arrives, drops that response, and then frees itself without a writeback.

Top module: `uncached_load_buffer`

## Requirements
- R1: After reset every entry is free: `busReqValid` and `wbValid` are low, and a request presented in the first cycle is accepted.
- R2: An accepted request (`reqValid` high, `flushValid` low, some entry free) raises `reqAccept` in the same cycle and takes the lowest-numbered free entry. That index is the id it later carries on `busReqId`.
- R3: When `reqValid` is high, `flushValid` is low and no entry is free, `reqReplay` is high and `reqAccept` is low in that cycle.
- R4: `busReqValid` is high whenever an entry waits to issue. `busReqId` and `busReqAddr` belong to the oldest such entry; on equal ages the lower index wins.
- R5: An entry leaves the waiting-to-issue state only in a cycle where `busReqValid` and `busReqReady` are both high and it is the selected entry. Otherwise its request stays offered unchanged.
- R6: A response is delivered to the entry whose index equals `busRespId`, and only if that entry is waiting for a response. A response for any other id changes nothing.
- R7: An entry that has received its response raises `wbValid` from the next cycle. `wbData` is the response data and `wbAge` is the entry's age. When several entries hold data, the oldest is offered first, with the lower index winning on a tie.
- R8: An entry is released after the cycle in which `wbValid` and `wbReady` are both high for it. It can be allocated again from the following cycle.
- R9: A cycle with `flushValid` high allocates nothing and signals no replay. In that cycle every entry whose age is the same as or younger than `flushAge`, and that is waiting to issue or to write back, is released.
- R10: An entry that is waiting for a response, or is sent, in a flush cycle that hits it, absorbs its later response and is released without ever raising `wbValid`.
- R11: Ages compare modulo 2^AGE_W: age a is older than age b when (a - b), taken as an AGE_W-bit two's-complement value, is negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Pipeline presents an uncached load |
| reqAddr | input | ADDR_W | Load address |
| reqAge | input | AGE_W | Program-order age tag of the load |
| reqAccept | output | 1 | Load taken into an entry this cycle |
| reqReplay | output | 1 | Load rejected because no entry is free |
| flushValid | input | 1 | Pipeline flush |
| flushAge | input | AGE_W | Oldest age removed by the flush |
| busReqValid | output | 1 | Outgoing bus request valid |
| busReqReady | input | 1 | Bus buffer takes the request |
| busReqAddr | output | ADDR_W | Address of the outgoing request |
| busReqId | output | log2(NUM_ENTRIES) | Entry index used as transaction id |
| busRespValid | input | 1 | Bus response valid |
| busRespId | input | log2(NUM_ENTRIES) | Transaction id of the response |
| busRespData | input | DATA_W | Response data |
| wbValid | output | 1 | Writeback to the pipeline valid |
| wbReady | input | 1 | Pipeline accepts the writeback |
| wbData | output | DATA_W | Loaded data |
| wbAge | output | AGE_W | Age tag of the written-back load |

## Verification
The hardest situation to reach from the ports is a flush that hits an entry after its request has left on the bus, followed later by the response for that entry. Random flushes alone seldom land in that window. The directed part therefore sends one specific entry, flushes at exactly its age while it waits, and then returns its id, expecting no writeback. Age wrap-around is also forced directly: a pair of ages that straddles zero shows that selection follows modular order. The random part lets the age counter wrap many times.

// File: rtl/ulb_pkg.sv
package ulb_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    ENT_IDLE       = 2'd0,
    ENT_WAIT_ISSUE = 2'd1,
    ENT_WAIT_RESP  = 2'd2,
    ENT_WAIT_WB    = 2'd3
  } ent_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic allocEn;  // capture request address and age
    logic respEn;   // capture response data
  } ulb_strobe_t;
endpackage

// File: rtl/ulb_oldest_pick.sv
module ulb_oldest_pick #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned AGE_W       = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES-1:0]       candMask,
  input  logic [NUM_ENTRIES*AGE_W-1:0] ageVec,
  output logic                         found,
  output logic [IDX_W-1:0]             idx
);
  timeunit 1ns;
  timeprecision 1ps;

  function automatic logic isOlder(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] diff;
    diff = a - b;
    return diff[AGE_W-1];
  endfunction

  logic [AGE_W-1:0] bestAge;
  logic [AGE_W-1:0] curAge;

  // linear scan; a later candidate replaces the best only when strictly older
  always_comb begin
    found   = 1'b0;
    idx     = '0;
    bestAge = '0;
    curAge  = '0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      curAge = ageVec[e*AGE_W +: AGE_W];
      if (candMask[e] && (!found || isOlder(curAge, bestAge))) begin
        found   = 1'b1;
        idx     = IDX_W'(e);
        bestAge = curAge;
      end
    end
  end
endmodule

// File: rtl/ulb_ctrl.sv
module ulb_ctrl
  import ulb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned AGE_W       = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  input  logic                         flushValid,
  input  logic [AGE_W-1:0]             flushAge,
  input  logic [NUM_ENTRIES*AGE_W-1:0] ageVec,
  input  logic                         busReqReady,
  input  logic                         busRespValid,
  input  logic [IDX_W-1:0]             busRespId,
  input  logic                         wbReady,
  output logic                         reqAccept,
  output logic                         reqReplay,
  output logic                         busReqValid,
  output logic [IDX_W-1:0]             busReqId,
  output logic                         wbValid,
  output logic [IDX_W-1:0]             wbIdx,
  output logic [IDX_W-1:0]             allocIdx,
  output ulb_strobe_t                  strobe,
  output logic [NUM_ENTRIES-1:0]       freeMask,
  output logic [NUM_ENTRIES-1:0]       issueMask,
  output logic [NUM_ENTRIES-1:0]       wbMask
);
  timeunit 1ns;
  timeprecision 1ps;

  function automatic logic isOlder(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] diff;
    diff = a - b;
    return diff[AGE_W-1];
  endfunction

  ent_state_e             entState [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] killed;
  logic [NUM_ENTRIES-1:0] flushHit;
  logic                   allocFound;
  logic                   respEn;
  logic                   sendFire;
  logic                   wbFire;

  // per-entry status and flush match
  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      issueMask[e] = (entState[e] == ENT_WAIT_ISSUE);
      wbMask[e]    = (entState[e] == ENT_WAIT_WB);
      flushHit[e]  = flushValid && !isOlder(ageVec[e*AGE_W +: AGE_W], flushAge);
    end
  end

  // free list: lowest-numbered free entry is handed out
  always_comb begin
    allocFound = 1'b0;
    allocIdx   = '0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (freeMask[e]) begin
        allocFound = 1'b1;
        allocIdx   = IDX_W'(e);
      end
    end
  end

  assign reqAccept = reqValid && !flushValid && allocFound;
  assign reqReplay = reqValid && !flushValid && !allocFound;

  ulb_oldest_pick #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_W(AGE_W)) u_sendPick (
    .candMask(issueMask), .ageVec(ageVec), .found(busReqValid), .idx(busReqId)
  );

  ulb_oldest_pick #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_W(AGE_W)) u_wbPick (
    .candMask(wbMask), .ageVec(ageVec), .found(wbValid), .idx(wbIdx)
  );

  assign respEn   = busRespValid && (entState[busRespId] == ENT_WAIT_RESP);
  assign sendFire = busReqValid && busReqReady;
  assign wbFire   = wbValid && wbReady;

  always_comb begin
    strobe.allocEn = reqAccept;
    strobe.respEn  = respEn;
  end

  // entry state machines and free list bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) entState[e] <= ENT_IDLE;
      killed   <= '0;
      freeMask <= '1;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        case (entState[e])
          ENT_IDLE: begin
            if (reqAccept && allocIdx == IDX_W'(e)) begin
              entState[e] <= ENT_WAIT_ISSUE;
              killed[e]   <= 1'b0;
              freeMask[e] <= 1'b0;
            end
          end
          ENT_WAIT_ISSUE: begin
            if (sendFire && busReqId == IDX_W'(e)) begin
              entState[e] <= ENT_WAIT_RESP;
              killed[e]   <= flushHit[e];
            end else if (flushHit[e]) begin
              entState[e] <= ENT_IDLE;
              freeMask[e] <= 1'b1;
            end
          end
          ENT_WAIT_RESP: begin
            if (respEn && busRespId == IDX_W'(e)) begin
              if (killed[e] || flushHit[e]) begin
                entState[e] <= ENT_IDLE;
                freeMask[e] <= 1'b1;
              end else begin
                entState[e] <= ENT_WAIT_WB;
              end
            end else if (flushHit[e]) begin
              killed[e] <= 1'b1;
            end
          end
          ENT_WAIT_WB: begin
            if ((wbFire && wbIdx == IDX_W'(e)) || flushHit[e]) begin
              entState[e] <= ENT_IDLE;
              freeMask[e] <= 1'b1;
            end
          end
          default: entState[e] <= ENT_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ulb_datapath.sv
module ulb_datapath
  import ulb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned AGE_W       = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ulb_strobe_t                  strobe,
  input  logic [IDX_W-1:0]             allocIdx,
  input  logic [IDX_W-1:0]             respIdx,
  input  logic [IDX_W-1:0]             sendIdx,
  input  logic [IDX_W-1:0]             wbIdx,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [AGE_W-1:0]             reqAge,
  input  logic [DATA_W-1:0]            respData,
  output logic [NUM_ENTRIES*AGE_W-1:0] ageVec,
  output logic [ADDR_W-1:0]            busReqAddr,
  output logic [DATA_W-1:0]            wbData,
  output logic [AGE_W-1:0]             wbAge
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [ADDR_W-1:0] addrMem [NUM_ENTRIES];
  logic [AGE_W-1:0]  ageMem  [NUM_ENTRIES];
  logic [DATA_W-1:0] dataMem [NUM_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        addrMem[e] <= '0;
        ageMem[e]  <= '0;
        dataMem[e] <= '0;
      end
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (strobe.allocEn && allocIdx == IDX_W'(e)) begin
          addrMem[e] <= reqAddr;
          ageMem[e]  <= reqAge;
        end
        if (strobe.respEn && respIdx == IDX_W'(e)) dataMem[e] <= respData;
      end
    end
  end

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) ageVec[e*AGE_W +: AGE_W] = ageMem[e];
  end

  assign busReqAddr = addrMem[sendIdx];
  assign wbData     = dataMem[wbIdx];
  assign wbAge      = ageMem[wbIdx];
endmodule

// File: rtl/uncached_load_buffer.sv
module uncached_load_buffer
  import ulb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned AGE_W       = 8,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [AGE_W-1:0]  reqAge,
  output logic              reqAccept,
  output logic              reqReplay,
  input  logic              flushValid,
  input  logic [AGE_W-1:0]  flushAge,
  output logic              busReqValid,
  input  logic              busReqReady,
  output logic [ADDR_W-1:0] busReqAddr,
  output logic [IDX_W-1:0]  busReqId,
  input  logic              busRespValid,
  input  logic [IDX_W-1:0]  busRespId,
  input  logic [DATA_W-1:0] busRespData,
  output logic              wbValid,
  input  logic              wbReady,
  output logic [DATA_W-1:0] wbData,
  output logic [AGE_W-1:0]  wbAge
);
  timeunit 1ns;
  timeprecision 1ps;

  ulb_strobe_t                  strobe;
  logic [IDX_W-1:0]             allocIdx;
  logic [IDX_W-1:0]             wbIdx;
  logic [NUM_ENTRIES*AGE_W-1:0] ageVec;
  logic [NUM_ENTRIES-1:0]       freeMask;
  logic [NUM_ENTRIES-1:0]       issueMask;
  logic [NUM_ENTRIES-1:0]       wbMask;

  ulb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .AGE_W(AGE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reqValid(reqValid), .flushValid(flushValid), .flushAge(flushAge),
    .ageVec(ageVec), .busReqReady(busReqReady),
    .busRespValid(busRespValid), .busRespId(busRespId), .wbReady(wbReady),
    .reqAccept(reqAccept), .reqReplay(reqReplay),
    .busReqValid(busReqValid), .busReqId(busReqId),
    .wbValid(wbValid), .wbIdx(wbIdx), .allocIdx(allocIdx), .strobe(strobe),
    .freeMask(freeMask), .issueMask(issueMask), .wbMask(wbMask)
  );

  ulb_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .AGE_W(AGE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocIdx(allocIdx), .respIdx(busRespId), .sendIdx(busReqId), .wbIdx(wbIdx),
    .reqAddr(reqAddr), .reqAge(reqAge), .respData(busRespData),
    .ageVec(ageVec), .busReqAddr(busReqAddr), .wbData(wbData), .wbAge(wbAge)
  );
endmodule

// File: rtl/ulb_checker.sv
module ulb_checker #(
  parameter int unsigned NUM_ENTRIES = 4,
  parameter int unsigned ADDR_W      = 32,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reqValid,
  input logic                   reqAccept,
  input logic                   reqReplay,
  input logic                   flushValid,
  input logic                   busReqValid,
  input logic                   busReqReady,
  input logic [IDX_W-1:0]       busReqId,
  input logic [ADDR_W-1:0]      busReqAddr,
  input logic                   wbValid,
  input logic [NUM_ENTRIES-1:0] freeMask,
  input logic [NUM_ENTRIES-1:0] issueMask,
  input logic [NUM_ENTRIES-1:0] wbMask
);
  timeunit 1ns;
  timeprecision 1ps;

  assert_replay_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reqReplay |-> (reqValid && !reqAccept && freeMask == '0));

  assert_accept_needs_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reqAccept |-> (freeMask != '0));

  assert_free_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (freeMask & (issueMask | wbMask)) == '0);

  assert_send_from_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid |-> issueMask[busReqId]);

  assert_send_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busReqValid && !busReqReady && !flushValid && !reqAccept)
      |=> (busReqValid && $stable(busReqId) && $stable(busReqAddr)));

  assert_wb_has_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (wbMask != '0));
endmodule

bind uncached_load_buffer ulb_checker #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAccept(reqAccept),
  .reqReplay(reqReplay), .flushValid(flushValid), .busReqValid(busReqValid),
  .busReqReady(busReqReady), .busReqId(busReqId), .busReqAddr(busReqAddr),
  .wbValid(wbValid), .freeMask(freeMask), .issueMask(issueMask), .wbMask(wbMask)
);

// File: tb/uncached_load_buffer_test.sv
module uncached_load_buffer_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N  = 4;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int GW = 8;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          rst_n;
  logic          reqValid;
  logic [AW-1:0] reqAddr;
  logic [GW-1:0] reqAge;
  logic          reqAccept, reqReplay;
  logic          flushValid;
  logic [GW-1:0] flushAge;
  logic          busReqValid, busReqReady;
  logic [AW-1:0] busReqAddr;
  logic [IW-1:0] busReqId;
  logic          busRespValid;
  logic [IW-1:0] busRespId;
  logic [DW-1:0] busRespData;
  logic          wbValid, wbReady;
  logic [DW-1:0] wbData;
  logic [GW-1:0] wbAge;

  uncached_load_buffer #(.NUM_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW), .AGE_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr), .reqAge(reqAge),
    .reqAccept(reqAccept), .reqReplay(reqReplay), .flushValid(flushValid), .flushAge(flushAge),
    .busReqValid(busReqValid), .busReqReady(busReqReady), .busReqAddr(busReqAddr),
    .busReqId(busReqId), .busRespValid(busRespValid), .busRespId(busRespId),
    .busRespData(busRespData), .wbValid(wbValid), .wbReady(wbReady),
    .wbData(wbData), .wbAge(wbAge)
  );

  // reference model: 0 free, 1 waiting to issue, 2 waiting for response, 3 waiting to write back
  int            mSt   [N];
  bit            mKill [N];
  logic [AW-1:0] mAddr [N];
  logic [GW-1:0] mAge  [N];
  logic [DW-1:0] mData [N];
  int            nChk = 0;
  int            nFail = 0;
  logic [GW-1:0] ageBase = 8'd40;

  function automatic bit older(logic [GW-1:0] a, logic [GW-1:0] b);
    logic [GW-1:0] d;
    d = a - b;
    return d[GW-1];
  endfunction

  function automatic int pickOldest(int want);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (mSt[i] == want && (best < 0 || older(mAge[i], mAge[best]))) best = i;
    return best;
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit rv, logic [AW-1:0] ra, logic [GW-1:0] rg,
                      bit fv, logic [GW-1:0] fg, bit brdy, bit rspv, int rspid,
                      logic [DW-1:0] rspd, bit wrdy);
    int            allocI, sI, wI;
    bit            expAcc, expRep, fh;
    int            nSt   [N];
    bit            nKill [N];
    logic [AW-1:0] nAddr [N];
    logic [GW-1:0] nAge  [N];
    logic [DW-1:0] nData [N];
    @(negedge clk);
    reqValid = rv; reqAddr = ra; reqAge = rg; flushValid = fv; flushAge = fg;
    busReqReady = brdy; busRespValid = rspv; busRespId = IW'(rspid);
    busRespData = rspd; wbReady = wrdy;
    #1;
    allocI = -1;
    for (int i = N - 1; i >= 0; i--) if (mSt[i] == 0) allocI = i;
    expAcc = rv && !fv && allocI >= 0;
    expRep = rv && !fv && allocI < 0;
    sI = pickOldest(1);
    wI = pickOldest(3);
    chk(tag, "reqAccept (R2)", 64'(reqAccept), 64'(expAcc));
    chk(tag, "reqReplay (R3)", 64'(reqReplay), 64'(expRep));
    chk(tag, "busReqValid (R4)", 64'(busReqValid), 64'(sI >= 0));
    if (sI >= 0) begin
      chk(tag, "busReqId (R4)", 64'(busReqId), 64'(sI));
      chk(tag, "busReqAddr (R4)", 64'(busReqAddr), 64'(mAddr[sI]));
    end
    chk(tag, "wbValid (R7)", 64'(wbValid), 64'(wI >= 0));
    if (wI >= 0) begin
      chk(tag, "wbData (R7)", wbData, mData[wI]);
      chk(tag, "wbAge (R7)", 64'(wbAge), 64'(mAge[wI]));
    end
    for (int i = 0; i < N; i++) begin
      nSt[i] = mSt[i]; nKill[i] = mKill[i]; nAddr[i] = mAddr[i];
      nAge[i] = mAge[i]; nData[i] = mData[i];
      fh = fv && !older(mAge[i], fg);
      case (mSt[i])
        0: if (expAcc && allocI == i) begin
             nSt[i] = 1; nKill[i] = 0; nAddr[i] = ra; nAge[i] = rg;
           end
        1: if (sI == i && brdy) begin nSt[i] = 2; nKill[i] = fh; end
           else if (fh) nSt[i] = 0;
        2: if (rspv && rspid == i) begin
             if (mKill[i] || fh) nSt[i] = 0;
             else begin nSt[i] = 3; nData[i] = rspd; end
           end else if (fh) nKill[i] = 1;
        default: if ((wI == i && wrdy) || fh) nSt[i] = 0;
      endcase
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      mSt[i] = nSt[i]; mKill[i] = nKill[i]; mAddr[i] = nAddr[i];
      mAge[i] = nAge[i]; mData[i] = nData[i];
    end
  endtask

  task automatic idleStep(string tag);
    step(tag, 0, '0, '0, 0, '0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int rid;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) begin
      mSt[i] = 0; mKill[i] = 0; mAddr[i] = '0; mAge[i] = '0; mData[i] = '0;
    end
    rst_n = 1'b0; reqValid = 0; reqAddr = '0; reqAge = '0; flushValid = 0; flushAge = '0;
    busReqReady = 0; busRespValid = 0; busRespId = '0; busRespData = '0; wbReady = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state, then a first request is taken
    idleStep("R1");
    step("R1", 1, 32'h100, 8'd13, 0, '0, 0, 0, 0, '0, 0);
    // R2: fill, lowest free index each time; ages descending so the oldest is entry 3
    step("R2", 1, 32'h104, 8'd12, 0, '0, 0, 0, 0, '0, 0);
    step("R2", 1, 32'h108, 8'd11, 0, '0, 0, 0, 0, '0, 0);
    step("R2", 1, 32'h10c, 8'd10, 0, '0, 0, 0, 0, '0, 0);
    // R3: full buffer replays
    step("R3", 1, 32'h110, 8'd14, 0, '0, 0, 0, 0, '0, 0);
    // R5: no ready, request stays offered
    idleStep("R5");
    idleStep("R5");
    // R4: oldest (entry 3) is sent
    step("R4", 0, '0, '0, 0, '0, 1, 0, 0, '0, 0);
    // R6: response for an entry not waiting is dropped, then the right one
    step("R6", 0, '0, '0, 0, '0, 0, 1, 0, 64'hdead, 0);
    step("R6", 0, '0, '0, 0, '0, 0, 1, 3, 64'h1122_3344_5566_7788, 0);
    // R7: writeback offered and held
    idleStep("R7");
    // R8: writeback taken, then entry 3 is reused
    step("R8", 0, '0, '0, 0, '0, 0, 0, 0, '0, 1);
    step("R8", 1, 32'h120, 8'd20, 0, '0, 0, 0, 0, '0, 0);
    // R9: send entry 2 (age 11), then flush at age 11 with a request present
    step("R9", 0, '0, '0, 0, '0, 1, 0, 0, '0, 0);
    step("R9", 1, 32'h124, 8'd21, 1, 8'd11, 0, 0, 0, '0, 0);
    idleStep("R9");
    // R10: flushed in-flight entry drops its response, no writeback
    step("R10", 0, '0, '0, 0, '0, 0, 1, 2, 64'hbad0_bad0, 0);
    idleStep("R10");
    idleStep("R10");
    // R11: ages around the wrap point
    step("R11", 1, 32'h200, 8'd250, 0, '0, 0, 0, 0, '0, 0);
    step("R11", 1, 32'h204, 8'd3, 0, '0, 0, 0, 0, '0, 0);
    idleStep("R11");
    step("R11", 0, '0, '0, 1, 8'd2, 0, 0, 0, '0, 0);
    step("R11", 0, '0, '0, 0, '0, 1, 0, 0, '0, 0);
    step("R11", 0, '0, '0, 0, '0, 0, 1, 0, 64'h2222, 1);
    idleStep("R11");
    ageBase = 8'd10;

    // random traffic over every requirement
    for (int c = 0; c < 4000; c++) begin
      bit            rv, fv, brdy, rspv, wrdy;
      logic [GW-1:0] rg, fg;
      rv   = ($urandom % 10) < 6;
      fv   = ($urandom % 25) == 0;
      brdy = ($urandom % 2) == 0;
      rspv = ($urandom % 5) < 2;
      wrdy = ($urandom % 2) == 0;
      if (rv) ageBase = ageBase + GW'(1 + $urandom % 3);
      rg = ageBase - GW'($urandom % 2);
      fg = ageBase - GW'($urandom % 8);
      rid = $urandom % N;
      if (($urandom % 4) != 0)
        for (int i = 0; i < N; i++) if (mSt[i] == 2) rid = i;
      step("R6", rv, $urandom, rg, fv, fg, brdy, rspv, rid,
           {$urandom, $urandom}, wrdy);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule